// File: doc/BRIEF.md
# CPU-Cycle Interrupt Timer for a Cartridge Mapper

This block is an interrupt timer that sits on the CPU side of a game cartridge mapper. Its clock is the CPU cycle clock (M2), so every rising edge of `clk_i` is one CPU cycle. The CPU programs a 16-bit start value in four 4-bit pieces, then arms the timer. Once armed, the counter steps up by one every CPU cycle. When it steps past its maximum value it restarts from the programmed value and raises an interrupt request, which stays asserted until software clears it.

All control happens through CPU writes, which are decoded from the top address bits. The write region at $8000-$BFFF takes the start-value nibbles. The region at $C000-$CFFF arms or disarms the timer. A write anywhere in $D000-$DFFF clears the pending interrupt; the data value of that write plays no part. The request output is active low so that it can share an open-drain interrupt line.

Top module: `cpu_irq_timer`

## Requirements
- R1: After reset the interrupt output `irq_no` is high (inactive), and it stays high while no write arms the timer.
- R2: A write with address bits 15:14 = 2'b10 stores data bits 3:0 into one nibble of the 16-bit start value. The nibble is chosen by address bits 13:12: 0 selects bits 3:0, 1 selects 7:4, 2 selects 11:8 and 3 selects 15:12. Address bits 11:0 and data bits 7:4 are ignored.
- R3: In a write with address bits 15:12 = 4'hC, data bit 0 sets the armed state: 1 arms the timer and 0 disarms it. Disarming also clears the pending interrupt, so `irq_no` is high after the clock edge that takes the write.
- R4: A write with address bits 15:12 = 4'hD clears the pending interrupt whatever the data value. If an overflow happens in the same cycle, the overflow wins and the interrupt stays pending.
- R5: A write that arms a disarmed timer loads the counter with the start value. An arming write while the timer is already armed does not reload the counter.
- R6: While armed, the counter increments once per clock edge. With start value S, the interrupt is asserted after the edge that lies 0x10000-S edges after the arming write, and not before.
- R7: On overflow the counter reloads the start value, so the interrupts repeat every 0x10000-S cycles. The pending interrupt stays asserted until an acknowledge write or a disarming write clears it.
- R8: `irq_no` is low exactly while an interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU cycle clock (M2); one rising edge per CPU cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe, high for the cycle in which the write happens |
| addr_i | input | 16 | CPU address |
| data_i | input | 8 | CPU write data |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that each CPU write is presented for exactly one clock edge, with address and data stable across that edge. They also assume that `wr_en_i` is never asserted on an edge where the address is still changing, which means that at most one register region is written per cycle. The bench meets these assumptions by changing all inputs on the falling clock edge and by dropping the strobe right after the single rising edge that takes each write. It places writes at exact edge counts from the arming write, so that an acknowledge and an overflow can land on the same edge.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  typedef enum logic [1:0] {
    OP_NONE,
    OP_NIBBLE,
    OP_ARM,
    OP_ACK
  } wr_op_e;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_timer_pkg::*;
(
  input  logic       wr_en_i,
  input  logic [3:0] addr_hi_i,
  output wr_op_e     op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (wr_en_i) begin
      if (addr_hi_i[3:2] == 2'b10)  op_o = OP_NIBBLE;
      else if (addr_hi_i == 4'hC)   op_o = OP_ARM;
      else if (addr_hi_i == 4'hD)   op_o = OP_ACK;
    end
  end
endmodule

// File: rtl/irq_reload_reg.sv
module irq_reload_reg #(
  parameter int CNT_W = 16,
  parameter int NIB_W = 4,
  localparam int NIB_N = CNT_W / NIB_W,
  localparam int IDX_W = (NIB_N > 1) ? $clog2(NIB_N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic [CNT_W-1:0] reload_o
);
  for (genvar g = 0; g < NIB_N; g++) begin : g_nib
    logic [NIB_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               q <= '0;
      else if (wr_i && idx_i == IDX_W'(g))       q <= nib_i;
    end
    assign reload_o[g*NIB_W +: NIB_W] = q;
  end
endmodule

// File: rtl/irq_up_counter.sv
module irq_up_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_wr_i,
  input  logic             arm_val_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             en_o,
  output logic             pend_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             en_q, pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             off_wr, start, wrap;

  assign off_wr = arm_wr_i && !arm_val_i;
  assign start  = arm_wr_i && arm_val_i && !en_q;
  // overflow is suppressed when the same edge disarms
  assign wrap   = en_q && !off_wr && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (arm_wr_i) en_q <= arm_val_i;

      if (start)                   cnt_q <= reload_i;
      else if (wrap)               cnt_q <= reload_i;
      else if (en_q && !off_wr)    cnt_q <= cnt_q + 1'b1;

      if (off_wr)      pend_q <= 1'b0;
      else if (wrap)   pend_q <= 1'b1;
      else if (ack_i)  pend_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/cpu_irq_timer.sv
module cpu_irq_timer
  import irq_timer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              irq_no
);
  localparam int NIB_N   = CNT_W / NIB_W;
  localparam int IDX_W   = (NIB_N > 1) ? $clog2(NIB_N) : 1;
  localparam int WIN_LSB = ADDR_W - 4;

  wr_op_e           op;
  logic [CNT_W-1:0] reload_w, cnt_w;
  logic             en_w, pend_w;
  logic             unused_bits;

  assign unused_bits = ^{addr_i[WIN_LSB-1:0], data_i[DATA_W-1:NIB_W]};

  irq_wr_decode u_dec (
    .wr_en_i   (wr_en_i),
    .addr_hi_i (addr_i[ADDR_W-1 -: 4]),
    .op_o      (op)
  );

  irq_reload_reg #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_rld (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (op == OP_NIBBLE),
    .idx_i    (addr_i[WIN_LSB +: IDX_W]),
    .nib_i    (data_i[NIB_W-1:0]),
    .reload_o (reload_w)
  );

  irq_up_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_wr_i  (op == OP_ARM),
    .arm_val_i (data_i[0]),
    .ack_i     (op == OP_ACK),
    .reload_i  (reload_w),
    .en_o      (en_w),
    .pend_o    (pend_w),
    .cnt_o     (cnt_w)
  );

  assign irq_no = ~pend_w;
endmodule

// File: rtl/cpu_irq_timer_chk.sv
module cpu_irq_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [3:0]       addr_hi_i,
  input logic             arm_bit_i,
  input logic             irq_no,
  input logic             en_q,
  input logic             pend_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q
);
  logic on_wr, off_wr, ack_wr, wrap;
  assign on_wr  = wr_en_i && addr_hi_i == 4'hC && arm_bit_i;
  assign off_wr = wr_en_i && addr_hi_i == 4'hC && !arm_bit_i;
  assign ack_wr = wr_en_i && addr_hi_i == 4'hD;
  assign wrap   = en_q && cnt_q == '1 && !off_wr;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !pend_q) |=> irq_no);
  p_disarm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_wr |=> (irq_no && !en_q));
  p_ack_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_wr && !wrap) |=> irq_no);
  p_arm_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_wr && !en_q) |=> (en_q && cnt_q == $past(reload_q)));
  p_count_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && cnt_q != '1 && !off_wr) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (!irq_no && cnt_q == $past(reload_q)));
  p_hold_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !on_wr) |=> $stable(cnt_q));
  p_pend_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_wr && !off_wr) |=> !irq_no);
endmodule

bind cpu_irq_timer cpu_irq_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_hi_i (addr_i[ADDR_W-1 -: 4]),
  .arm_bit_i (data_i[0]),
  .irq_no    (irq_no),
  .en_q      (en_w),
  .pend_q    (pend_w),
  .cnt_q     (cnt_w),
  .reload_q  (reload_w)
);

// File: tb/cpu_irq_timer_test.sv
module cpu_irq_timer_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        irq_n;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_irq_timer uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .data_i  (data),
    .irq_no  (irq_n)
  );

  task automatic check(input string tag, input logic exp);
    total++;
    if (irq_n !== exp) begin
      bad++;
      $display("FAIL %s: irq_no=%0b expected=%0b", tag, irq_n, exp);
    end
  endtask

  // called at a falling edge; the next rising edge takes the write
  task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
    addr = a; data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; addr = '0; data = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset", 1'b1);
    cyc(40);
    check("R1 idle", 1'b1);
    check("R8 idle", 1'b1);
  endtask

  // start value 0xFFF0 -> period 16
  task automatic t_period;
    cpu_wr(16'h8000, 8'h00);
    cpu_wr(16'h9000, 8'h0F);
    cpu_wr(16'hA000, 8'h0F);
    cpu_wr(16'hB000, 8'h0F);
    cpu_wr(16'hC000, 8'hFF);              // edge E
    cyc(15);  check("R6 before overflow", 1'b1);
    cyc(1);   check("R6 at overflow", 1'b0);
    cyc(3);   check("R7 sticky", 1'b0);
    cpu_wr(16'hD000, 8'h00);              // E+20
    check("R4 ack data 00", 1'b1);
    cyc(11);  check("R7 before 2nd overflow", 1'b1);
    cpu_wr(16'hD000, 8'hFF);              // E+32, overflow same edge
    check("R4 overflow beats ack", 1'b0);
    cpu_wr(16'hDFFF, 8'h5A);              // E+33
    check("R4 ack other data", 1'b1);
    cyc(14);  check("R7 before 3rd overflow", 1'b1);
    cyc(1);   check("R7 3rd overflow", 1'b0);
    cpu_wr(16'hC000, 8'h00);
    check("R3 disarm clears", 1'b1);
    cyc(40);  check("R3 stays disarmed", 1'b1);
  endtask

  task automatic t_no_rearm;
    cpu_wr(16'hC000, 8'hFF);              // E
    cyc(4);
    cpu_wr(16'hC000, 8'hFF);              // E+5, already armed
    cyc(10);  check("R5 no reload before", 1'b1);
    cyc(1);   check("R5 no reload overflow", 1'b0);
    cpu_wr(16'hCFFF, 8'h00);
    check("R3 disarm", 1'b1);
  endtask

  // start value 0xFFC5 -> period 59, odd addresses and junk high bits
  task automatic t_nibbles;
    cpu_wr(16'hBFFF, 8'hEF);
    cpu_wr(16'h8F3C, 8'hA5);
    cpu_wr(16'hA001, 8'h3F);
    cpu_wr(16'h9ABC, 8'h7C);
    cpu_wr(16'hC7E3, 8'h01);              // E
    cyc(58);  check("R2 nibble map before", 1'b1);
    cyc(1);   check("R2 nibble map overflow", 1'b0);
    check("R8 pending low", 1'b0);
    cpu_wr(16'hC000, 8'hFE);
    check("R3 bit0 zero disarms", 1'b1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_period();
    t_no_rearm();
    t_nibbles();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: state=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule